// File: doc/BRIEF.md
# Accumulator Group Execution Unit

This block holds a 4-bit accumulator and a carry flag, and it carries out the single-word instructions that work only on these two. The instruction decoder sends the lower nibble of the instruction word together with a one-cycle strobe. On the clock edge that samples the strobe, the block writes the new accumulator and carry values into its registers. The operations are carry clear, set and complement; increment and decrement; rotates that pass through the carry; moves from the carry into the accumulator; a decimal adjust step used after binary addition of BCD digits; and a conversion from a one-hot key nibble to a key index.

The accumulator and the carry are outputs, so the rest of the datapath can read them directly. When the strobe is low, or when the strobe comes with a code the block does not define, both registers keep their values.

Top module: `ag_exec_unit`

## Requirements
- R1: A high `rst` on a clock edge sets the accumulator to 0 and the carry to 0 from that edge on.
- R2: With `op_valid` low, or with code 4, 13, 14 or 15, the accumulator and the carry keep their values.
- R3: Code 0 clears the accumulator and the carry. Code 1 clears the carry. Code 10 sets the carry. Code 3 inverts the carry. Codes 1, 3 and 10 leave the accumulator unchanged.
- R4: Code 2 writes accumulator+1 modulo 16. It sets the carry to 1 exactly when the old accumulator was 15, and to 0 otherwise.
- R5: Code 8 writes accumulator-1 modulo 16. It sets the carry to 0 exactly when the old accumulator was 0, and to 1 otherwise.
- R6: Code 5 moves the old accumulator bit 3 into the carry and shifts the old carry into accumulator bit 0. Code 6 moves the old accumulator bit 0 into the carry and shifts the old carry into accumulator bit 3.
- R7: Code 7 writes the old carry into the accumulator (value 0 or 1) and clears the carry.
- R8: Code 9 writes 10 into the accumulator if the carry was 1 and 9 if it was 0, then clears the carry.
- R9: Code 11 adds 6 to the accumulator modulo 16 when the accumulator is above 9 or the carry is 1. If that sum exceeds 15, the carry is set; otherwise the carry is left as it was. When neither condition holds, nothing changes.
- R10: Code 12 maps accumulator 0, 1, 2, 4 and 8 to 0, 1, 2, 3 and 4, and maps every other value to 15. The carry is unchanged.
- R11: Each result appears on `acc_q` and `carry_q` right after the clock edge that samples `op_valid` high, so back-to-back strobes chain their results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Strobe; the code is executed on this edge |
| op_code | input | 4 | Lower nibble of the instruction word |
| acc_q | output | DATA_W | Accumulator |
| carry_q | output | 1 | Carry flag |

## Verification
The assertions assume that `op_code` is a known value in every cycle where `op_valid` is high, and that the checked properties look only at cycles after reset has been released. The bench keeps to this. It drives the strobe and the code at the falling edge and holds the code steady for the whole cycle.

The bench reaches each of the 32 accumulator-and-carry states through the block's own instructions: clear, then increment repeatedly, then set the carry if needed. It then applies every one of the 16 codes to every state. It also strobes random codes with `op_valid` low, and these must leave the state unchanged.

// File: rtl/ag_pkg.sv
package ag_pkg;

    typedef enum logic [3:0] {
        OP_CLR_ALL   = 4'h0,
        OP_CLR_CY    = 4'h1,
        OP_INC       = 4'h2,
        OP_CPL_CY    = 4'h3,
        OP_ROT_L     = 4'h5,
        OP_ROT_R     = 4'h6,
        OP_CY_TO_ACC = 4'h7,
        OP_DEC       = 4'h8,
        OP_CY_SUB    = 4'h9,
        OP_SET_CY    = 4'hA,
        OP_DEC_ADJ   = 4'hB,
        OP_KEY_IDX   = 4'hC
    } ag_op_e;

    typedef enum logic [3:0] {
        SEL_HOLD,
        SEL_CLR_ALL,
        SEL_CLR_CY,
        SEL_SET_CY,
        SEL_CPL_CY,
        SEL_INC,
        SEL_DEC,
        SEL_ROT_L,
        SEL_ROT_R,
        SEL_CY_TO_ACC,
        SEL_CY_SUB,
        SEL_DEC_ADJ,
        SEL_KEY_IDX
    } ag_sel_e;

    localparam int unsigned AG_DATA_W = 4;
    localparam int unsigned AG_DEC_LIMIT = 9;
    localparam int unsigned AG_DEC_ADJ = 6;
    localparam int unsigned AG_TCS_HI = 10;
    localparam int unsigned AG_TCS_LO = 9;

    function automatic ag_sel_e ag_decode_op(input logic [3:0] code);
        ag_sel_e s;
        case (code)
            OP_CLR_ALL:   s = SEL_CLR_ALL;
            OP_CLR_CY:    s = SEL_CLR_CY;
            OP_INC:       s = SEL_INC;
            OP_CPL_CY:    s = SEL_CPL_CY;
            OP_ROT_L:     s = SEL_ROT_L;
            OP_ROT_R:     s = SEL_ROT_R;
            OP_CY_TO_ACC: s = SEL_CY_TO_ACC;
            OP_DEC:       s = SEL_DEC;
            OP_CY_SUB:    s = SEL_CY_SUB;
            OP_SET_CY:    s = SEL_SET_CY;
            OP_DEC_ADJ:   s = SEL_DEC_ADJ;
            OP_KEY_IDX:   s = SEL_KEY_IDX;
            default:      s = SEL_HOLD;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ag_decode.sv
module ag_decode
    import ag_pkg::*;
(
    input  logic       op_valid,
    input  logic [3:0] op_code,
    output ag_sel_e    sel
);
    always_comb begin
        if (op_valid) sel = ag_decode_op(op_code);
        else          sel = SEL_HOLD;
    end
endmodule

// File: rtl/ag_arith.sv
module ag_arith
    import ag_pkg::*;
#(
    parameter int unsigned DATA_W = AG_DATA_W
) (
    input  logic [DATA_W-1:0] acc,
    input  logic              cy,
    output logic [DATA_W-1:0] inc_acc,
    output logic              inc_cy,
    output logic [DATA_W-1:0] dec_acc,
    output logic              dec_cy,
    output logic [DATA_W-1:0] adj_acc,
    output logic              adj_cy,
    output logic [DATA_W-1:0] sub_acc
);
    localparam logic [DATA_W:0]   ONE_X   = (DATA_W+1)'(1);
    localparam logic [DATA_W:0]   ADJ_X   = (DATA_W+1)'(AG_DEC_ADJ);
    localparam logic [DATA_W-1:0] LIMIT   = DATA_W'(AG_DEC_LIMIT);
    localparam logic [DATA_W-1:0] SUB_HI  = DATA_W'(AG_TCS_HI);
    localparam logic [DATA_W-1:0] SUB_LO  = DATA_W'(AG_TCS_LO);

    logic [DATA_W:0] inc_sum;
    logic [DATA_W:0] dec_diff;
    logic [DATA_W:0] adj_sum;
    logic            adj_need;

    always_comb begin
        inc_sum  = {1'b0, acc} + ONE_X;
        inc_acc  = inc_sum[DATA_W-1:0];
        inc_cy   = inc_sum[DATA_W];

        dec_diff = {1'b0, acc} - ONE_X;
        dec_acc  = dec_diff[DATA_W-1:0];
        dec_cy   = ~dec_diff[DATA_W];

        adj_need = (acc > LIMIT) || cy;
        adj_sum  = {1'b0, acc} + ADJ_X;
        if (adj_need) begin
            adj_acc = adj_sum[DATA_W-1:0];
            adj_cy  = cy | adj_sum[DATA_W];
        end else begin
            adj_acc = acc;
            adj_cy  = cy;
        end

        sub_acc = cy ? SUB_HI : SUB_LO;
    end

    always_comb begin
        if (!$isunknown(acc)) begin
            a_inc_wrap_r4: assert (inc_cy == (inc_acc == '0));
            a_dec_wrap_r5: assert (dec_cy == (acc != '0));
        end
    end
endmodule

// File: rtl/ag_bitops.sv
module ag_bitops
    import ag_pkg::*;
#(
    parameter int unsigned DATA_W = AG_DATA_W
) (
    input  logic [DATA_W-1:0] acc,
    input  logic              cy,
    output logic [DATA_W-1:0] rl_acc,
    output logic              rl_cy,
    output logic [DATA_W-1:0] rr_acc,
    output logic              rr_cy,
    output logic [DATA_W-1:0] key_acc
);
    localparam int unsigned IDX_W = $clog2(DATA_W + 1);

    logic [IDX_W-1:0] idx;
    logic             hit;

    assign rl_acc = {acc[DATA_W-2:0], cy};
    assign rl_cy  = acc[DATA_W-1];
    assign rr_acc = {cy, acc[DATA_W-1:1]};
    assign rr_cy  = acc[0];

    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int b = 0; b < DATA_W; b++) begin
            if (acc[b]) begin
                idx = IDX_W'(b + 1);
                hit = 1'b1;
            end
        end
        if (acc == '0)        key_acc = '0;
        else if ($onehot(acc) && hit) key_acc = DATA_W'(idx);
        else                  key_acc = '1;
    end
endmodule

// File: rtl/ag_exec_unit.sv
module ag_exec_unit
    import ag_pkg::*;
#(
    parameter int unsigned DATA_W = AG_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    output logic [DATA_W-1:0] acc_q,
    output logic              carry_q
);
    ag_sel_e           sel;
    logic [DATA_W-1:0] inc_acc, dec_acc, adj_acc, sub_acc;
    logic              inc_cy, dec_cy, adj_cy;
    logic [DATA_W-1:0] rl_acc, rr_acc, key_acc;
    logic              rl_cy, rr_cy;
    logic [DATA_W-1:0] acc_d;
    logic              cy_d;

    ag_decode u_dec (
        .op_valid (op_valid),
        .op_code  (op_code),
        .sel      (sel)
    );

    ag_arith #(.DATA_W(DATA_W)) u_arith (
        .acc     (acc_q),
        .cy      (carry_q),
        .inc_acc (inc_acc),
        .inc_cy  (inc_cy),
        .dec_acc (dec_acc),
        .dec_cy  (dec_cy),
        .adj_acc (adj_acc),
        .adj_cy  (adj_cy),
        .sub_acc (sub_acc)
    );

    ag_bitops #(.DATA_W(DATA_W)) u_bits (
        .acc     (acc_q),
        .cy      (carry_q),
        .rl_acc  (rl_acc),
        .rl_cy   (rl_cy),
        .rr_acc  (rr_acc),
        .rr_cy   (rr_cy),
        .key_acc (key_acc)
    );

    always_comb begin
        acc_d = acc_q;
        cy_d  = carry_q;
        unique case (sel)
            SEL_CLR_ALL:   begin acc_d = '0; cy_d = 1'b0; end
            SEL_CLR_CY:    cy_d = 1'b0;
            SEL_SET_CY:    cy_d = 1'b1;
            SEL_CPL_CY:    cy_d = ~carry_q;
            SEL_INC:       begin acc_d = inc_acc; cy_d = inc_cy; end
            SEL_DEC:       begin acc_d = dec_acc; cy_d = dec_cy; end
            SEL_ROT_L:     begin acc_d = rl_acc;  cy_d = rl_cy;  end
            SEL_ROT_R:     begin acc_d = rr_acc;  cy_d = rr_cy;  end
            SEL_CY_TO_ACC: begin acc_d = {{(DATA_W-1){1'b0}}, carry_q}; cy_d = 1'b0; end
            SEL_CY_SUB:    begin acc_d = sub_acc; cy_d = 1'b0; end
            SEL_DEC_ADJ:   begin acc_d = adj_acc; cy_d = adj_cy; end
            SEL_KEY_IDX:   acc_d = key_acc;
            default:       ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            acc_q   <= acc_d;
            carry_q <= cy_d;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (acc_q == '0) && !carry_q);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(acc_q) && $stable(carry_q));

    p_clear_all_r3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_CLR_ALL) |=> (acc_q == '0) && !carry_q);

    p_rot_left_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_ROT_L) |=>
            (carry_q == $past(acc_q[DATA_W-1])) && (acc_q[0] == $past(carry_q)));

    p_cy_move_r7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_CY_TO_ACC) |=>
            (acc_q == {{(DATA_W-1){1'b0}}, $past(carry_q)}) && !carry_q);

    p_adj_keeps_cy_r9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_DEC_ADJ && carry_q) |=> carry_q);

    p_key_range_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_KEY_IDX) |=>
            ((acc_q <= DATA_W'(DATA_W)) || (acc_q == '1)) && $stable(carry_q));
endmodule

// File: tb/ag_exec_unit_bench.sv
module ag_exec_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = 4'h0;
    logic [3:0] acc_q;
    logic       carry_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ag_exec_unit u_ag_exec_unit (
        .clk     (clk),
        .rst     (rst),
        .op_valid(op_valid),
        .op_code (op_code),
        .acc_q   (acc_q),
        .carry_q (carry_q)
    );

    function automatic string tag_of(input int op);
        case (op)
            0, 1, 3, 10: return "R3";
            2:  return "R4";
            8:  return "R5";
            5, 6: return "R6";
            7:  return "R7";
            9:  return "R8";
            11: return "R9";
            12: return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic ref_step(input int op, input int a, input int c,
                            output int na, output int nc);
        na = a; nc = c;
        case (op)
            0:  begin na = 0; nc = 0; end
            1:  nc = 0;
            2:  begin na = (a + 1) % 16; nc = (a == 15) ? 1 : 0; end
            3:  nc = 1 - c;
            5:  begin na = ((a * 2) % 16) + c; nc = a / 8; end
            6:  begin na = (a / 2) + 8 * c; nc = a % 2; end
            7:  begin na = c; nc = 0; end
            8:  begin na = (a + 15) % 16; nc = (a == 0) ? 0 : 1; end
            9:  begin na = c ? 10 : 9; nc = 0; end
            10: nc = 1;
            11: if (a > 9 || c == 1) begin
                    na = (a + 6) % 16;
                    if (a + 6 > 15) nc = 1;
                end
            12: case (a)
                    0: na = 0; 1: na = 1; 2: na = 2; 4: na = 3; 8: na = 4;
                    default: na = 15;
                endcase
            default: ;
        endcase
    endtask

    task automatic check(input string tag, input int ea, input int ec);
        n_chk++;
        if (int'(acc_q) != ea || int'(carry_q) != ec) begin
            n_bad++;
            $display("FAIL %s: acc=%0d carry=%0d expected acc=%0d carry=%0d",
                     tag, acc_q, carry_q, ea, ec);
        end
    endtask

    task automatic issue(input int op);
        op_valid = 1'b1;
        op_code  = 4'(op);
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic reach(input int a, input int c);
        issue(0);
        for (int k = 0; k < a; k++) issue(2);
        if (c != 0) issue(10);
    endtask

    initial begin
        int na, nc;
        repeat (3) @(negedge clk);
        check("R1", 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", 0, 0);

        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int c = 0; c < 2; c++) begin
                    reach(a, c);
                    check("R11", a, c);
                    ref_step(op, a, c, na, nc);
                    issue(op);
                    check(tag_of(op), na, nc);
                end
            end
        end

        for (int a = 0; a < 16; a++) begin
            reach(a, a % 2);
            for (int k = 0; k < 4; k++) begin
                op_code = 4'($urandom_range(0, 15));
                @(posedge clk);
                @(negedge clk);
                check("R2", a, a % 2);
            end
        end

        reach(7, 1);
        issue(11);
        issue(2);
        check("R11", 14, 0);

        reach(13, 1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", 0, 0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11: watchdog expired, actual=hung expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule